// File: doc/BRIEF.md
# OTG Wrapper Interrupt Aggregator

This block collects interrupt sources around a USB OTG controller and presents them to software as two groups of sticky status bits behind a small register bus, with one combined interrupt line. The "misc" group watches four OTG control outputs: VBUS drive, VBUS charge, VBUS discharge and ID pull-up. It records a rising-edge event and a falling-edge event for each line. It also latches an OTG event pulse and a DMA-disable-cleared pulse. The "core" group latches the controller core's interrupt request.

Software masks each bit through a pair of registers: an enable-set register and an enable-clear register, both write-one. It acknowledges events by writing ones to the status register, so writing back a value just read clears exactly what was seen. A raw view shows all pending bits. A masked view shows only the enabled ones.

The interrupt line is driven by a three-state machine: IRQ_IDLE, IRQ_ACTIVE and IRQ_REARM. The transitions are:
- IDLE to ACTIVE when any masked bit is pending.
- ACTIVE to IDLE when nothing masked is pending.
- ACTIVE to REARM on an end-of-interrupt write.
- REARM to ACTIVE when something is still pending, otherwise REARM to IDLE.

The line is high only in IRQ_ACTIVE. The one-cycle drop through IRQ_REARM lets an edge-triggered interrupt controller see a fresh edge.

Top module: `otgw_irq_agg`

## Requirements
- R1: After reset every status bit and enable bit reads zero, the edge reference of each control line is zero, and irq_o is low.
- R2: ctrl_i[3] is VBUS drive, ctrl_i[2] is VBUS charge, ctrl_i[1] is VBUS discharge and ctrl_i[0] is ID pull-up. A line that is 1 after being 0 on the previous clock sets misc bit 13, 12, 11 or 8 respectively. A line that is 0 after being 1 sets misc bit 5, 4, 3 or 0 respectively. The bit reads as set in the raw view right after the clock edge that sampled the change.
- R3: A high otg_evt_i sets misc bit 16. A high dma_clr_evt_i sets misc bit 17. A high core_irq_i sets core bit 0. All three are set on the sampling clock edge.
- R4: Address 0 (misc) and address 4 (core) return the raw pending bits whatever the enables. Address 1 (misc) and address 5 (core) return raw AND enable. Pending bits that are not enabled never raise irq_o.
- R5: A write to address 2 (misc) or address 6 (core) sets the enable bits written as one and leaves the others unchanged. Reading address 2, 3, 6 or 7 returns the current enable mask of its group. Bits without a source read zero.
- R6: A write to address 3 (misc) or address 7 (core) clears the enable bits written as one and leaves the others unchanged.
- R7: A write to address 1 or address 5 clears the status bits of that group written as one, whether or not they are enabled, and leaves the others pending.
- R8: When an event and a clearing write hit the same status bit on the same clock edge, the bit stays set.
- R9: irq_o rises one clock after any masked bit of either group becomes pending. It falls one clock after no masked bit is pending.
- R10: A write to address 8 with wdata bit 0 equal to the line number (0) while irq_o is high drops irq_o for exactly one clock. irq_o then returns high if a masked bit is still pending. An end-of-interrupt write with any other line number has no effect.
- R11: Writes to the raw addresses 0 and 4 change nothing. Addresses 8 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 4 | OTG control lines: [3] drive, [2] charge, [1] discharge, [0] ID pull-up |
| core_irq_i | input | 1 | Core interrupt request |
| otg_evt_i | input | 1 | OTG event pulse |
| dma_clr_evt_i | input | 1 | DMA-disable-cleared pulse |
| bus_addr_i | input | 4 | Register word address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| irq_o | output | 1 | Combined interrupt line |

## Verification
Timing is counted per register on the path:
- An event sampled at clock edge k shows in the raw and masked views immediately after edge k, because read data is combinational from the status flops.
- irq_o follows one edge later, at k+1, because the state register adds a stage.
- A clearing write at edge k removes the status bit after edge k, but irq_o only falls after edge k+1.
- An end-of-interrupt write at edge k drops irq_o after edge k and restores it after edge k+1.

The bench drives every input on the falling edge and samples on the following falling edge. It counts rising edges explicitly between stimulus and sample, so each check lands on the cycle these counts predict.

// File: rtl/otgw_irq_pkg.sv
package otgw_irq_pkg;

    localparam int OTGW_DATA_W   = 32;
    localparam int OTGW_ADDR_W   = 4;
    localparam int OTGW_NUM_CTRL = 4;

    // Register word addresses
    localparam int A_MISC_RAW  = 0;
    localparam int A_MISC_STAT = 1;
    localparam int A_MISC_ESET = 2;
    localparam int A_MISC_ECLR = 3;
    localparam int A_CORE_RAW  = 4;
    localparam int A_CORE_STAT = 5;
    localparam int A_CORE_ESET = 6;
    localparam int A_CORE_ECLR = 7;
    localparam int A_EOI       = 8;

    // Fixed event positions decoded by software
    localparam int POS_OTG_EVT = 16;
    localparam int POS_DMA_CLR = 17;
    localparam int POS_CORE    = 0;

    // Line 0 is ID pull-up, 1 discharge, 2 charge, 3 drive
    function automatic int rise_pos(input int line);
        return (line == 0) ? 8 : (10 + line);
    endfunction

    function automatic int fall_pos(input int line);
        return (line == 0) ? 0 : (2 + line);
    endfunction

    function automatic logic [OTGW_DATA_W-1:0] misc_impl_mask();
        logic [OTGW_DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < OTGW_NUM_CTRL; i++) begin
            m[rise_pos(i)] = 1'b1;
            m[fall_pos(i)] = 1'b1;
        end
        m[POS_OTG_EVT] = 1'b1;
        m[POS_DMA_CLR] = 1'b1;
        return m;
    endfunction

    localparam logic [OTGW_DATA_W-1:0] MISC_IMPL = misc_impl_mask();
    localparam logic [OTGW_DATA_W-1:0] CORE_IMPL = OTGW_DATA_W'(1) << POS_CORE;

    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_ACTIVE = 2'd1,
        IRQ_REARM  = 2'd2
    } irq_state_e;

endpackage

// File: rtl/otgw_edge_det.sv
module otgw_edge_det #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lines_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= '0;
        end else begin
            prev_q <= lines_i;
        end
    end

    always_comb begin
        rise_o =  lines_i & ~prev_q;
        fall_o = ~lines_i &  prev_q;
    end

endmodule

// File: rtl/otgw_evt_bank.sv
module otgw_evt_bank #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] stat_clr_i,
    input  logic [W-1:0] en_set_i,
    input  logic [W-1:0] en_clr_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] masked_o
);

    logic [W-1:0] stat_q, stat_d;
    logic [W-1:0] en_q, en_d;

    always_comb begin
        // a fresh event overrides an acknowledge on the same edge
        stat_d = ((stat_q & ~stat_clr_i) | evt_i) & IMPL;
        en_d   = ((en_q | en_set_i) & ~en_clr_i) & IMPL;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            en_q   <= en_d;
        end
    end

    always_comb begin
        raw_o    = stat_q;
        en_o     = en_q;
        masked_o = stat_q & en_q;
    end

endmodule

// File: rtl/otgw_irq_line.sv
module otgw_irq_line
    import otgw_irq_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pend_i,
    input  logic eoi_i,
    output logic irq_o
);

    irq_state_e st_q, st_d;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= IRQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_IDLE: begin
                if (pend_i) st_d = IRQ_ACTIVE;
            end
            IRQ_ACTIVE: begin
                if (eoi_i)        st_d = IRQ_REARM;
                else if (!pend_i) st_d = IRQ_IDLE;
            end
            IRQ_REARM: begin
                st_d = pend_i ? IRQ_ACTIVE : IRQ_IDLE;
            end
            default: st_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (st_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/otgw_irq_agg.sv
module otgw_irq_agg
    import otgw_irq_pkg::*;
#(
    parameter int   ADDR_W  = OTGW_ADDR_W,
    parameter int   DATA_W  = OTGW_DATA_W,
    parameter logic LINE_ID = 1'b0
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [OTGW_NUM_CTRL-1:0] ctrl_i,
    input  logic                     core_irq_i,
    input  logic                     otg_evt_i,
    input  logic                     dma_clr_evt_i,
    input  logic [ADDR_W-1:0]        bus_addr_i,
    input  logic                     bus_we_i,
    input  logic [DATA_W-1:0]        bus_wdata_i,
    output logic [DATA_W-1:0]        bus_rdata_o,
    output logic                     irq_o
);

    localparam logic [DATA_W-1:0] M_IMPL = DATA_W'(MISC_IMPL);
    localparam logic [DATA_W-1:0] C_IMPL = DATA_W'(CORE_IMPL);

    logic [OTGW_NUM_CTRL-1:0] ctrl_rise, ctrl_fall;
    logic [DATA_W-1:0] misc_evt, core_evt;
    logic [DATA_W-1:0] misc_sclr, misc_eset, misc_eclr;
    logic [DATA_W-1:0] core_sclr, core_eset, core_eclr;
    logic [DATA_W-1:0] misc_raw, misc_en, misc_masked;
    logic [DATA_W-1:0] core_raw, core_en, core_masked;
    logic              eoi_hit;
    logic              any_pend;

    otgw_edge_det #(.N(OTGW_NUM_CTRL)) u_edge (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .lines_i (ctrl_i),
        .rise_o  (ctrl_rise),
        .fall_o  (ctrl_fall)
    );

    // Place edge events at their fixed positions
    always_comb begin
        misc_evt = '0;
        for (int i = 0; i < OTGW_NUM_CTRL; i++) begin
            misc_evt[rise_pos(i)] = ctrl_rise[i];
            misc_evt[fall_pos(i)] = ctrl_fall[i];
        end
        misc_evt[POS_OTG_EVT] = otg_evt_i;
        misc_evt[POS_DMA_CLR] = dma_clr_evt_i;
        core_evt              = '0;
        core_evt[POS_CORE]    = core_irq_i;
    end

    // Write decode: each strobe vector is the write data when its address is hit
    function automatic logic [DATA_W-1:0] wr_vec(input int a);
        return (bus_we_i && (bus_addr_i == ADDR_W'(a))) ? bus_wdata_i : '0;
    endfunction

    always_comb begin
        misc_sclr = wr_vec(A_MISC_STAT);
        misc_eset = wr_vec(A_MISC_ESET);
        misc_eclr = wr_vec(A_MISC_ECLR);
        core_sclr = wr_vec(A_CORE_STAT);
        core_eset = wr_vec(A_CORE_ESET);
        core_eclr = wr_vec(A_CORE_ECLR);
        eoi_hit   = bus_we_i && (bus_addr_i == ADDR_W'(A_EOI))
                    && (bus_wdata_i[0] == LINE_ID);
    end

    otgw_evt_bank #(.W(DATA_W), .IMPL(M_IMPL)) u_misc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (misc_evt),
        .stat_clr_i (misc_sclr),
        .en_set_i   (misc_eset),
        .en_clr_i   (misc_eclr),
        .raw_o      (misc_raw),
        .en_o       (misc_en),
        .masked_o   (misc_masked)
    );

    otgw_evt_bank #(.W(DATA_W), .IMPL(C_IMPL)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (core_evt),
        .stat_clr_i (core_sclr),
        .en_set_i   (core_eset),
        .en_clr_i   (core_eclr),
        .raw_o      (core_raw),
        .en_o       (core_en),
        .masked_o   (core_masked)
    );

    always_comb begin
        any_pend = (|misc_masked) | (|core_masked);
    end

    otgw_irq_line u_line (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pend_i (any_pend),
        .eoi_i  (eoi_hit),
        .irq_o  (irq_o)
    );

    // Read mux
    always_comb begin
        case (bus_addr_i)
            ADDR_W'(A_MISC_RAW):  bus_rdata_o = misc_raw;
            ADDR_W'(A_MISC_STAT): bus_rdata_o = misc_masked;
            ADDR_W'(A_MISC_ESET): bus_rdata_o = misc_en;
            ADDR_W'(A_MISC_ECLR): bus_rdata_o = misc_en;
            ADDR_W'(A_CORE_RAW):  bus_rdata_o = core_raw;
            ADDR_W'(A_CORE_STAT): bus_rdata_o = core_masked;
            ADDR_W'(A_CORE_ESET): bus_rdata_o = core_en;
            ADDR_W'(A_CORE_ECLR): bus_rdata_o = core_en;
            default:              bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/otgw_irq_agg_chk.sv
module otgw_irq_agg_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        ctrl,
    input logic              core_irq,
    input logic              irq,
    input logic              eoi,
    input logic              we,
    input logic [3:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] m_evt,
    input logic [DATA_W-1:0] m_raw,
    input logic [DATA_W-1:0] m_en,
    input logic [DATA_W-1:0] m_masked,
    input logic [DATA_W-1:0] c_raw,
    input logic [DATA_W-1:0] c_masked
);

    localparam logic [DATA_W-1:0] M_IMPL = DATA_W'(otgw_irq_pkg::MISC_IMPL);

    p_rise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl[0]) |=> m_raw[8]);

    p_fall_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl[3]) |=> m_raw[5]);

    p_core_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_irq |=> c_raw[0]);

    p_en_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 4'd2) |=> ((m_en & M_IMPL & $past(wdata)) == (M_IMPL & $past(wdata))));

    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_evt) |=> ((m_raw & $past(m_evt)) == $past(m_evt)));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((|m_masked) || (|c_masked)));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ((|m_masked) || (|c_masked)) && !eoi) |=> irq);

    p_eoi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && eoi) |=> !irq);

endmodule

bind otgw_irq_agg otgw_irq_agg_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .ctrl     (ctrl_i),
    .core_irq (core_irq_i),
    .irq      (irq_o),
    .eoi      (eoi_hit),
    .we       (bus_we_i),
    .addr     (bus_addr_i),
    .wdata    (bus_wdata_i),
    .m_evt    (misc_evt),
    .m_raw    (misc_raw),
    .m_en     (misc_en),
    .m_masked (misc_masked),
    .c_raw    (core_raw),
    .c_masked (core_masked)
);

// File: tb/test_otgw_irq_agg.sv
module test_otgw_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ctrl = '0;
    logic        core_irq = 1'b0;
    logic        otg_evt = 1'b0;
    logic        dma_evt = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    otgw_irq_agg i_otgw_irq_agg (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .ctrl_i        (ctrl),
        .core_irq_i    (core_irq),
        .otg_evt_i     (otg_evt),
        .dma_clr_evt_i (dma_evt),
        .bus_addr_i    (addr),
        .bus_we_i      (we),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .irq_o         (irq)
    );

    int rise_tab [4] = '{8, 11, 12, 13};
    int fall_tab [4] = '{0, 3, 4, 5};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), v);
            chk("R1 regs", v, 32'h0);
        end
    endtask

    task automatic t_edges();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ctrl[i] = 1'b1;
            tick(1);
            rd(4'd0, v);
            chk("R2 rise", v, 32'h1 << rise_tab[i]);
            wr(4'd1, 32'h1 << rise_tab[i]);
            rd(4'd0, v);
            chk("R7 clear unenabled", v, 32'h0);
            ctrl[i] = 1'b0;
            tick(1);
            rd(4'd0, v);
            chk("R2 fall", v, 32'h1 << fall_tab[i]);
            chk("R4 no irq when masked", {31'b0, irq}, 32'h0);
            wr(4'd1, 32'h1 << fall_tab[i]);
        end
    endtask

    task automatic t_pulses();
        logic [31:0] v;
        @(negedge clk);
        otg_evt = 1'b1; dma_evt = 1'b1; core_irq = 1'b1;
        tick(1);
        otg_evt = 1'b0; dma_evt = 1'b0; core_irq = 1'b0;
        rd(4'd0, v);
        chk("R3 otg/dma bits", v, 32'h0003_0000);
        rd(4'd4, v);
        chk("R3 core bit", v, 32'h1);
        rd(4'd5, v);
        chk("R4 core masked", v, 32'h0);
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd5, 32'h1);
        rd(4'd0, v);
        chk("R7 misc cleared", v, 32'h0);
        rd(4'd4, v);
        chk("R7 core cleared", v, 32'h0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, v);
        chk("R5 impl mask", v, 32'h0003_3939);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd2, 32'h0001_0100);
        wr(4'd2, 32'h0);
        rd(4'd2, v);
        chk("R5 set readback", v, 32'h0001_0100);
        rd(4'd3, v);
        chk("R5 clr addr readback", v, 32'h0001_0100);
        @(negedge clk);
        otg_evt = 1'b1; dma_evt = 1'b1;
        @(posedge clk);
        @(negedge clk);
        otg_evt = 1'b0; dma_evt = 1'b0;
        rd(4'd0, v);
        chk("R4 raw", v, 32'h0003_0000);
        rd(4'd1, v);
        chk("R4 masked", v, 32'h0001_0000);
        chk("R9 irq not yet", {31'b0, irq}, 32'h0);
        tick(1);
        chk("R9 irq rises", {31'b0, irq}, 32'h1);
        wr(4'd3, 32'h0000_0100);
        wr(4'd3, 32'h0);
        rd(4'd2, v);
        chk("R6 clr", v, 32'h0001_0000);
        rd(4'd1, v);
        wr(4'd1, v);
        chk("R9 irq lags clear", {31'b0, irq}, 32'h1);
        tick(1);
        chk("R9 irq falls", {31'b0, irq}, 32'h0);
        rd(4'd0, v);
        chk("R7 writeback keeps unread", v, 32'h0002_0000);
        wr(4'd1, 32'h0002_0000);
        wr(4'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_core_irq();
        logic [31:0] v;
        wr(4'd6, 32'h1);
        rd(4'd7, v);
        chk("R5 core en", v, 32'h1);
        @(negedge clk);
        core_irq = 1'b1;
        tick(1);
        core_irq = 1'b0;
        rd(4'd5, v);
        chk("R4 core masked", v, 32'h1);
        tick(1);
        chk("R9 core irq", {31'b0, irq}, 32'h1);
        wr(4'd5, 32'h1);
        tick(1);
        chk("R9 core irq falls", {31'b0, irq}, 32'h0);
        wr(4'd7, 32'h1);
    endtask

    task automatic t_evt_wins();
        logic [31:0] v;
        @(negedge clk);
        otg_evt = 1'b1;
        addr = 4'd1; wdata = 32'h0001_0000; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        otg_evt = 1'b0; we = 1'b0; wdata = '0;
        rd(4'd0, v);
        chk("R8 event wins", v, 32'h0001_0000);
        wr(4'd1, 32'h0001_0000);
        rd(4'd0, v);
        chk("R8 later clear", v, 32'h0);
    endtask

    task automatic t_eoi();
        logic [31:0] v;
        wr(4'd2, 32'h0001_0000);
        @(negedge clk);
        otg_evt = 1'b1;
        tick(1);
        otg_evt = 1'b0;
        tick(1);
        chk("R10 irq up", {31'b0, irq}, 32'h1);
        wr(4'd8, 32'h1);
        chk("R10 wrong line ignored", {31'b0, irq}, 32'h1);
        tick(1);
        chk("R10 wrong line still high", {31'b0, irq}, 32'h1);
        wr(4'd8, 32'h0);
        chk("R10 dip", {31'b0, irq}, 32'h0);
        tick(1);
        chk("R10 reassert", {31'b0, irq}, 32'h1);
        wr(4'd1, 32'h0001_0000);
        tick(1);
        chk("R10 idle after clear", {31'b0, irq}, 32'h0);
        wr(4'd8, 32'h0);
        tick(1);
        chk("R10 eoi while idle", {31'b0, irq}, 32'h0);
        wr(4'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        @(negedge clk);
        dma_evt = 1'b1;
        tick(1);
        dma_evt = 1'b0;
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd0, v);
        chk("R11 raw write ignored", v, 32'h0002_0000);
        rd(4'd2, v);
        chk("R11 enable untouched", v, 32'h0);
        rd(4'd4, v);
        chk("R11 core raw untouched", v, 32'h0);
        for (int a = 8; a < 16; a++) begin
            rd(4'(a), v);
            chk("R11 unmapped zero", v, 32'h0);
        end
        wr(4'd1, 32'h0002_0000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edges();
        t_pulses();
        t_mask_irq();
        t_core_irq();
        t_evt_wins();
        t_eoi();
        t_ignored();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        finish_run();
    end

endmodule